// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous requester and an external asynchronous static RAM with 17 address bits and 8 data bits. The requester raises a request with a write flag, an address and write data while the controller shows ready. The controller then drives the memory's address bus, its active-low chip-enable, write-enable and output-enable strobes, and a split tri-state data bus (value, enable, and returned value). It plays out a fixed sequence of phases and counts each one in clock cycles.

Every phase length comes from a minimum time in nanoseconds and the clock period, both parameters. Each time is rounded up to whole cycles, and a nonzero time never becomes less than one cycle. A write has three phases: address presentation with write-enable high, a write-enable low pulse with data driven, and a hold cycle. In the hold cycle write-enable rises while address and data stay unchanged, so the memory latches the data on that edge. A read holds output-enable low for the access time and registers the bus on the last access cycle. It then pulses read-data-valid for one clock during a recovery phase. In that phase output-enable is high and no driver is on, which gives the memory time to release the bus before any later write can drive it.

Top module: `sram_bus_ctrl`

## Requirements
- R1: During and after reset, chip-enable, write-enable and output-enable are high (inactive), the data-bus enable is low, ready is high and read-data-valid is low.
- R2: Strobe encoding: idle is chip-enable high; a write phase has chip-enable low with output-enable high; a read access has chip-enable low, write-enable high and output-enable low. Write-enable and output-enable are never low in the same cycle, and write-enable is never low while chip-enable is high.
- R3: An accepted write presents the latched address with chip-enable low and write-enable high for SETUP cycles. It then holds write-enable low with the data driven for PULSE cycles, and then raises write-enable for HOLD cycles. Address, data and data-bus enable are unchanged across the rising edge of write-enable.
- R4: The write-enable low pulse lasts at least ceil(max(write pulse, chip-enable-to-end, address-to-end, data-to-end) / period) cycles. The data is driven for that whole pulse.
- R5: An accepted read holds output-enable low for ACC = ceil(max(address access, output-enable access, read cycle) / period) cycles and registers the data bus on the last of them. In the next cycle read-data-valid is high for exactly one clock, with that data on the read-data output.
- R6: The data-bus enable is high only in cycles where output-enable is high and was also high in the previous cycle.
- R7: After a read access, output-enable stays high, the data drivers stay off and ready stays low for RECOV = max(1, ceil(output-disable time / period)) cycles.
- R8: Ready is high only in idle. Changes on request, write flag, address and write data while ready is low have no effect on the operation in progress or on memory contents.
- R9: Ready returns exactly SETUP+PULSE+HOLD cycles after a write is accepted and ACC+RECOV cycles after a read is accepted. A request present in the first idle cycle is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, taken when ready_o is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Request address |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | Controller idle, request accepted this cycle |
| rvalid_o | output | 1 | One-cycle read data valid |
| rdata_o | output | 8 | Read data |
| mem_addr_o | output | 17 | Memory address bus |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 8 | Data bus value driven to memory |
| mem_dq_oe_o | output | 1 | Data bus driver enable |
| mem_dq_i | input | 8 | Data bus value from memory |

## Verification
The assertions assume that the clock period parameter matches the real clock, and that the requester holds its request fields steady in the cycle in which ready is high. They also assume that the memory drives the bus only when the strobes select a read. The bench drives all inputs at the falling edge and raises request only in idle cycles. While the controller is busy it drives deliberately conflicting request values, which tests that they are ignored. Its memory model puts data on the bus only under the read encoding and latches writes only on a write-enable rising edge.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_W_SETUP,
    PH_W_PULSE,
    PH_W_HOLD,
    PH_R_ACCESS,
    PH_R_RECOV
  } phase_e;

  function automatic int unsigned ns_to_cyc(int unsigned t_ns, int unsigned period_ns);
    if (t_ns == 0) return 0;
    return (t_ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= len_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned SETUP_LEN = 1,
  parameter int unsigned PULSE_LEN = 1,
  parameter int unsigned HOLD_LEN  = 1,
  parameter int unsigned ACC_LEN   = 1,
  parameter int unsigned RECOV_LEN = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             last_i,
  output logic             load_o,
  output logic [CNT_W-1:0] len_o,
  output phase_e           state_d_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             ready_o
);
  phase_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    load_o    = 1'b0;
    len_o     = '0;
    capture_o = 1'b0;
    unique case (state_q)
      PH_IDLE: if (req_i) begin
        load_o  = 1'b1;
        state_d = we_i ? PH_W_SETUP : PH_R_ACCESS;
        len_o   = we_i ? CNT_W'(SETUP_LEN) : CNT_W'(ACC_LEN);
      end
      PH_W_SETUP: if (last_i) begin
        state_d = PH_W_PULSE;
        load_o  = 1'b1;
        len_o   = CNT_W'(PULSE_LEN);
      end
      PH_W_PULSE: if (last_i) begin
        state_d = PH_W_HOLD;
        load_o  = 1'b1;
        len_o   = CNT_W'(HOLD_LEN);
      end
      PH_W_HOLD: if (last_i) state_d = PH_IDLE;
      PH_R_ACCESS: if (last_i) begin
        state_d   = PH_R_RECOV;
        load_o    = 1'b1;
        len_o     = CNT_W'(RECOV_LEN);
        capture_o = 1'b1;
      end
      PH_R_RECOV: if (last_i) state_d = PH_IDLE;
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PH_IDLE;
    else         state_q <= state_d;
  end

  assign state_d_o = state_d;
  assign ready_o   = (state_q == PH_IDLE);
  assign accept_o  = ready_o & req_i;
endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            state_d_i,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic              mem_dq_oe_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  // strobes registered from next phase: glitch-free pins aligned to the phase register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_ce_no   <= 1'b1;
      mem_we_no   <= 1'b1;
      mem_oe_no   <= 1'b1;
      mem_dq_oe_o <= 1'b0;
    end else begin
      mem_ce_no   <= (state_d_i == PH_IDLE);
      mem_we_no   <= (state_d_i != PH_W_PULSE);
      mem_oe_no   <= (state_d_i != PH_R_ACCESS);
      mem_dq_oe_o <= (state_d_i == PH_W_PULSE) || (state_d_i == PH_W_HOLD);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      mem_dq_o   <= '0;
    end else if (accept_i) begin
      mem_addr_o <= addr_i;
      mem_dq_o   <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= capture_i;
      if (capture_i) rdata_o <= mem_dq_i;
    end
  end
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned T_WP_NS       = 8,
  parameter int unsigned T_CW_NS       = 8,
  parameter int unsigned T_AW_NS       = 8,
  parameter int unsigned T_AS_NS       = 0,
  parameter int unsigned T_DW_NS       = 6,
  parameter int unsigned T_DH_NS       = 0,
  parameter int unsigned T_WC_NS       = 12,
  parameter int unsigned T_RC_NS       = 12,
  parameter int unsigned T_AA_NS       = 12,
  parameter int unsigned T_OE_NS       = 6,
  parameter int unsigned T_OHZ_NS      = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned SETUP_LEN = max2(1, ns_to_cyc(T_AS_NS, CLK_PERIOD_NS));
  localparam int unsigned HOLD_LEN  = max2(1, ns_to_cyc(T_DH_NS, CLK_PERIOD_NS));
  localparam int unsigned WC_CYC    = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
  localparam int unsigned WC_REM    = (WC_CYC > SETUP_LEN + HOLD_LEN) ? WC_CYC - SETUP_LEN - HOLD_LEN : 0;
  localparam int unsigned PULSE_LEN = max2(max2(max2(1, WC_REM),
                                                max2(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS), ns_to_cyc(T_CW_NS, CLK_PERIOD_NS))),
                                           max2(ns_to_cyc(T_AW_NS, CLK_PERIOD_NS), ns_to_cyc(T_DW_NS, CLK_PERIOD_NS)));
  localparam int unsigned ACC_LEN   = max2(max2(1, ns_to_cyc(T_RC_NS, CLK_PERIOD_NS)),
                                           max2(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS), ns_to_cyc(T_OE_NS, CLK_PERIOD_NS)));
  localparam int unsigned RECOV_LEN = max2(1, ns_to_cyc(T_OHZ_NS, CLK_PERIOD_NS));
  localparam int unsigned MAX_LEN   = max2(max2(SETUP_LEN, HOLD_LEN), max2(max2(PULSE_LEN, ACC_LEN), RECOV_LEN));
  localparam int unsigned CNT_W     = $clog2(MAX_LEN + 1);

  logic             load, last, accept, capture;
  logic [CNT_W-1:0] len;
  phase_e           state_d;

  sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i, .rst_ni, .load_i(load), .len_i(len), .last_o(last)
  );

  sram_ctrl_fsm #(
    .CNT_W(CNT_W), .SETUP_LEN(SETUP_LEN), .PULSE_LEN(PULSE_LEN),
    .HOLD_LEN(HOLD_LEN), .ACC_LEN(ACC_LEN), .RECOV_LEN(RECOV_LEN)
  ) i_fsm (
    .clk_i, .rst_ni, .req_i, .we_i, .last_i(last), .load_o(load), .len_o(len),
    .state_d_o(state_d), .accept_o(accept), .capture_o(capture), .ready_o
  );

  sram_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pins (
    .clk_i, .rst_ni, .state_d_i(state_d), .accept_i(accept), .capture_i(capture),
    .addr_i, .wdata_i, .mem_dq_i, .mem_addr_o, .mem_dq_o, .mem_ce_no, .mem_we_no,
    .mem_oe_no, .mem_dq_oe_o, .rvalid_o, .rdata_o
  );
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned T_WP_NS       = 8,
  parameter int unsigned T_DW_NS       = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_no,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o
);
  logic [7:0] we_low_q, drv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_low_q <= '0;
      drv_q    <= '0;
    end else begin
      we_low_q <= !mem_we_no ? ((we_low_q == 8'hff) ? we_low_q : we_low_q + 8'd1) : 8'd0;
      drv_q    <= (mem_dq_oe_o && !mem_we_no) ? ((drv_q == 8'hff) ? drv_q : drv_q + 8'd1) : 8'd0;
    end
  end

  AST_IDLE_STANDBY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> mem_ce_no && mem_we_no && mem_oe_no && !mem_dq_oe_o); // R1
  AST_WE_OE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_oe_no && !mem_ce_no); // R2
  AST_WRITE_EDGE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> $stable(mem_addr_o) && $stable(mem_dq_o) && mem_dq_oe_o && !mem_ce_no); // R3
  AST_WE_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (32'(we_low_q) * CLK_PERIOD_NS >= T_WP_NS)
                      && (32'(drv_q) * CLK_PERIOD_NS >= T_DW_NS)); // R4
  AST_RVALID_AFTER_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rvalid_o) |-> $past(!mem_oe_no) && mem_oe_no); // R5
  AST_RVALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o); // R5
  AST_NO_CONTENTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> mem_oe_no && $past(mem_oe_no)); // R6
  AST_DRIVE_ONLY_OE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no); // R6
  AST_RECOV_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> !ready_o && mem_oe_no && !mem_dq_oe_o); // R7
endmodule

bind sram_bus_ctrl sram_ctrl_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .T_WP_NS(T_WP_NS), .T_DW_NS(T_DW_NS)
) i_sram_ctrl_checker (
  .clk_i, .rst_ni, .ready_o, .rvalid_o, .mem_addr_o, .mem_ce_no,
  .mem_we_no, .mem_oe_no, .mem_dq_o, .mem_dq_oe_o
);

// File: tb/test_sram_bus_ctrl.sv
module test_sram_bus_ctrl;
  localparam int AW = 17, DW = 8, PER = 20;
  // bench-side phase lengths from the timing minimums (ceil, floor of one)
  function automatic int cy(int t); return (t == 0) ? 0 : (t + PER - 1) / PER; endfunction
  function automatic int mx(int a, int b); return a > b ? a : b; endfunction
  localparam int SETUP = mx(1, cy(0));
  localparam int HOLD  = mx(1, cy(0));
  localparam int PULSE = mx(mx(mx(cy(8), cy(6)), mx(cy(8), cy(8))), mx(1, cy(12) - SETUP - HOLD));
  localparam int ACC   = mx(mx(cy(12), cy(6)), mx(1, cy(12)));
  localparam int RECOV = mx(1, cy(5));

  logic clk = 0, rst_ni = 0;
  logic req_i = 0, we_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic ready_o, rvalid_o, mem_ce_no, mem_we_no, mem_oe_no, mem_dq_oe_o;
  logic [DW-1:0] rdata_o, mem_dq_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_dq_i = '0;

  always #(PER/2) clk = ~clk;

  sram_bus_ctrl i_sram_bus_ctrl (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .ready_o, .rvalid_o,
    .rdata_o, .mem_addr_o, .mem_ce_no, .mem_we_no, .mem_oe_no, .mem_dq_o,
    .mem_dq_oe_o, .mem_dq_i
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [DW-1:0] sram_mem [int];   // memory model contents
  logic [DW-1:0] exp_mem  [int];   // reference expected contents

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pins(string req, bit ce, bit we, bit oe, bit dqoe, bit rdy, bit rv);
    chk(req, "ce_n", mem_ce_no, ce);
    chk(req, "we_n", mem_we_no, we);
    chk(req, "oe_n", mem_oe_no, oe);
    chk(req, "dq_oe", mem_dq_oe_o, dqoe);
    chk(req, "ready", ready_o, rdy);
    chk(req, "rvalid", rvalid_o, rv);
  endtask

  // memory model: drives only under the read encoding
  logic model_drv, model_drv_prev = 0, we_prev = 1;
  int we_low = 0;
  assign model_drv = !mem_ce_no && mem_we_no && !mem_oe_no;
  always @(mem_addr_o or mem_oe_no or mem_ce_no or mem_we_no)
    mem_dq_i = (!mem_ce_no && mem_we_no && !mem_oe_no && sram_mem.exists(int'(mem_addr_o)))
               ? sram_mem[int'(mem_addr_o)] : '0;

  always @(negedge clk) if (rst_ni) begin
    if (mem_dq_oe_o && (model_drv || model_drv_prev))
      chk("R6", "bus contention", 1, 0);
    if (!mem_we_no && !mem_oe_no) chk("R2", "we and oe both low", 1, 0);
    if (!we_prev && mem_we_no) begin
      chk("R4", "we pulse ok", (we_low * PER >= 8) ? 1 : 0, 1);
      chk("R3", "data driven at we rise", mem_dq_oe_o, 1);
      sram_mem[int'(mem_addr_o)] = mem_dq_o;
    end
    we_low = !mem_we_no ? we_low + 1 : 0;
    we_prev = mem_we_no;
    model_drv_prev = model_drv;
  end

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d, bit noise);
    @(negedge clk);
    pins("R9", 1, 1, 1, 0, 1, 0);  // idle cycle, request taken here
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    exp_mem[int'(a)] = d;
    for (int i = 0; i < SETUP; i++) begin
      @(negedge clk);
      if (noise) begin req_i = 1; we_i = 0; addr_i = ~a; wdata_i = ~d; end  // R8 stimulus
      else req_i = 0;
      pins("R3", 0, 1, 1, 0, 0, 0);
      chk("R3", "addr setup", mem_addr_o, a);
    end
    for (int i = 0; i < PULSE; i++) begin
      @(negedge clk);
      pins("R4", 0, 0, 1, 1, 0, 0);
      chk("R3", "addr pulse", mem_addr_o, a);
      chk("R3", "data pulse", mem_dq_o, d);
    end
    for (int i = 0; i < HOLD; i++) begin
      @(negedge clk);
      req_i = 0;
      pins("R3", 0, 1, 1, 1, 0, 0);
      chk("R8", "addr hold", mem_addr_o, a);
      chk("R8", "data hold", mem_dq_o, d);
    end
  endtask

  task automatic do_read(logic [AW-1:0] a);
    logic [DW-1:0] e;
    e = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : '0;
    @(negedge clk);
    pins("R9", 1, 1, 1, 0, 1, 0);
    req_i = 1; we_i = 0; addr_i = a;
    for (int i = 0; i < ACC; i++) begin
      @(negedge clk);
      req_i = 0;
      pins("R5", 0, 1, 0, 0, 0, 0);
      chk("R2", "read addr", mem_addr_o, a);
    end
    for (int i = 0; i < RECOV; i++) begin
      @(negedge clk);
      pins("R7", 0, 1, 1, 0, 0, (i == 0) ? 1 : 0);
      if (i == 0) chk("R5", "read data", rdata_o, e);
    end
  endtask

  initial begin
    logic [AW-1:0] pool [8];
    repeat (2) @(negedge clk);
    pins("R1", 1, 1, 1, 0, 1, 0);
    rst_ni = 1;
    @(negedge clk);
    pins("R1", 1, 1, 1, 0, 1, 0);
    // directed: boundary addresses and data patterns
    do_write(17'h00000, 8'h00, 0);
    do_write(17'h1ffff, 8'hff, 0);
    do_read(17'h1ffff);
    do_read(17'h00000);
    do_read(17'h0abcd);             // never written
    do_write(17'h05555, 8'h5a, 1);  // busy-time request noise
    do_read(17'h05555);
    do_read(~17'h05555);            // noise address untouched
    do_read(17'h05555);             // read then write back to back
    do_write(17'h05555, 8'ha5, 0);
    do_read(17'h05555);
    // random sequences on a small pool for read-after-write hits
    for (int i = 0; i < 8; i++) pool[i] = AW'($urandom);
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      a = ($urandom % 4 == 0) ? AW'($urandom) : pool[$urandom % 8];
      if ($urandom % 2) do_write(a, DW'($urandom), ($urandom % 3) == 0);
      else do_read(a);
    end
    @(negedge clk);
    pins("R9", 1, 1, 1, 0, 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule